// File: doc/BRIEF.md
# I2C Slave Address Matcher with Bit Masking

This block sits behind the bit-level receiver of an I2C slave and decides whether the address phase that follows a Start or repeated Start is meant for this device. It takes each shifted byte with a one-cycle valid strobe, together with bus-event pulses for Start, Stop and a not-acknowledged byte. It compares the address against a locally held own-address byte, and the host can tell it to ignore selected address bits. The result is an acknowledge pulse for the address byte, a one-cycle match pulse, and the captured transfer direction with its own validity flag.

Both 7-bit and 10-bit addressing are handled. In 10-bit mode the own-address byte is time-shared. The host first loads the high-byte pattern, then the low address byte, then the high-byte pattern again. A sticky "reload needed" flag asks for each reload. The flag drops when the host writes the register. A general-call address of zero can be accepted when enabled. A data/address indicator tells the host whether the last byte seen in a selected transfer was address or data.

Top module: `i2c_addr_match`

## Requirements
- R1: After a synchronous active-low reset all outputs are 0 and the own-address byte is 0x00.
- R2: In 7-bit mode (`wide_mode`=0) the first byte after a Start matches when its bits 7:1 equal own-address bits 7:1 outside the ignored positions. On a match, `addr_hit` and `addr_ack` pulse for the one cycle after the strobe, `rw_dir` takes byte bit 0 (1 = read) and `rw_valid` rises.
- R3: `mask_sel[4:1]` set to 1 make own-address bits 5:2 (one mask bit per address bit, in order) take no part in the comparison.
- R4: `mask_sel[0]` removes own-address bit 1 from the comparison in 7-bit mode. It removes bits 1 and 0 of the 10-bit low byte in 10-bit mode.
- R5: An address byte of 0x00 is matched as a general call (write, `rw_dir`=0) only while `gcall_en`=1. An address field of zero never matches the own address.
- R6: In 10-bit mode a first byte of the form 11110xx0 whose bits 2:1 equal own-address bits 2:1 gets `addr_ack` without `addr_hit` and sets `need_addr_upd`. The own-address register must then hold 11110 in bits 7:3. The next byte is then treated as the low address byte.
- R7: A low byte equal to the own-address byte outside the ignored positions gives `addr_hit`, `addr_ack` and `rw_dir`=0, and sets `need_addr_upd` again. Any mismatch gives no acknowledge.
- R8: After a full 10-bit write match, a repeated Start followed by the matching high byte with bit 0 = 1 gives `addr_hit`, `addr_ack` and `rw_dir`=1. Without such a prior match in the same transfer, a Stop in between included, it gets no acknowledge.
- R9: `need_addr_upd` clears when `addr_we` writes the own address. If it is set and written in the same cycle, it stays set.
- R10: `rw_valid` clears on Start, Stop or not-acknowledge. None of these events may coincide with `byte_vld`.
- R11: `data_phase` clears on every address match and sets on each byte that follows in the selected transfer. After a mismatched address all bytes are ignored until the next Start: no pulses, and `data_phase` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_det | input | 1 | Start or repeated Start seen (one-cycle pulse) |
| stop_det | input | 1 | Stop seen (one-cycle pulse) |
| nack_det | input | 1 | A byte was not acknowledged by the master (pulse) |
| byte_vld | input | 1 | Strobe: `rx_byte` holds a complete received byte |
| rx_byte | input | 8 | Received byte, MSB first on the wire |
| addr_we | input | 1 | Host write strobe for the own-address byte |
| addr_wdata | input | 8 | Own-address byte to write |
| wide_mode | input | 1 | 1 = 10-bit addressing, 0 = 7-bit |
| gcall_en | input | 1 | Accept the general-call address |
| mask_sel | input | 5 | Per-bit ignore selects, see R3 and R4 |
| addr_hit | output | 1 | One-cycle pulse: transfer addressed to this slave |
| addr_ack | output | 1 | One-cycle pulse: acknowledge this address byte |
| rw_dir | output | 1 | Captured direction, 1 = read |
| rw_valid | output | 1 | `rw_dir` is current |
| need_addr_upd | output | 1 | Host must reload the own-address byte |
| data_phase | output | 1 | 1 = last byte was data, 0 = address |

## Verification
The assertions assume that the bus-event pulses and the byte strobe never share a cycle, and that the host writes the own address only between bytes or in the same cycle as a strobe. The stimulus drives every strobe and pulse for exactly one cycle with idle cycles around it, and it loads the own address through its own write task. Random 7-bit and 10-bit transfers draw their addresses either from the own address with bits flipped in the ignored positions or from fully random values. This covers hits, general calls and misses.

// File: rtl/i2c_addr_match_pkg.sv
// Shared types and helpers for the I2C slave address matcher.
// Assumes an 8-bit byte lane and a 5-bit ignore-select field.
package i2c_addr_match_pkg;

    localparam int BYTE_W = 8;
    localparam int MASK_W = 5;

    // Sequencer position within an address phase.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // not selected, wait for Start
        ST_ADDR = 2'd1,   // next byte is first address byte
        ST_LOW  = 2'd2,   // 10-bit: next byte is low address byte
        ST_DATA = 2'd3    // selected, bytes are data
    } am_state_t;

    // Build the per-bit ignore vector from the mask selects and the mode.
    function automatic logic [BYTE_W-1:0] ignore_vec(input logic [MASK_W-1:0] msk,
                                                     input logic wide);
        logic [BYTE_W-1:0] v;
        v = '0;
        for (int i = 1; i < MASK_W; i++) begin
            v[i+1] = msk[i];
        end
        v[1] = msk[0];
        v[0] = msk[0] & wide;
        return v;
    endfunction

endpackage

// File: rtl/i2c_addr_cmp.sv
// Combinational address comparator.
// Produces the four candidate decisions for one received byte; the
// sequencer picks which one applies. Assumes own_addr is registered.
module i2c_addr_cmp
    import i2c_addr_match_pkg::*;
#(
    parameter int W  = BYTE_W,
    parameter int MW = MASK_W
) (
    input  logic [W-1:0]  rx_byte,
    input  logic [W-1:0]  own_addr,
    input  logic [MW-1:0] mask_sel,
    input  logic          wide_mode,
    input  logic          gcall_en,
    output logic          gc_hit,
    output logic          hit7,
    output logic          hi10,
    output logic          lo10
);

    localparam logic [4:0] HI_TAG = 5'b11110;

    logic [W-1:0] ign;
    logic [W-1:0] diff;

    // Differences that survive the ignore vector.
    always_comb begin
        ign  = ignore_vec(mask_sel, wide_mode);
        diff = (rx_byte ^ own_addr) & ~ign;
    end

    // Decision terms for each address-byte kind.
    always_comb begin
        gc_hit = gcall_en && (rx_byte == '0);
        hit7   = (rx_byte[W-1:1] != '0) && (diff[W-1:1] == '0);
        hi10   = (rx_byte[W-1:W-5] == HI_TAG) && (rx_byte[W-1:1] == own_addr[W-1:1]);
        lo10   = (diff == '0);
    end

endmodule

// File: rtl/i2c_addr_seq.sv
// Address-phase sequencer.
// Walks Start -> address byte(s) -> data, issues the acknowledge and match
// pulses, holds the direction, the reload flag and the data/address flag.
// Assumes start/stop/nack pulses never coincide with byte_vld.
module i2c_addr_seq
    import i2c_addr_match_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_det,
    input  logic         stop_det,
    input  logic         nack_det,
    input  logic         byte_vld,
    input  logic [W-1:0] rx_byte,
    input  logic         addr_we,
    input  logic         wide_mode,
    input  logic         gcall_en,
    input  logic         gc_hit,
    input  logic         hit7,
    input  logic         hi10,
    input  logic         lo10,
    output logic         addr_hit,
    output logic         addr_ack,
    output logic         rw_dir,
    output logic         rw_valid,
    output logic         need_addr_upd,
    output logic         data_phase
);

    am_state_t st;
    logic      armed;   // full 10-bit write match seen in this transfer

    // Sequencer and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st            <= ST_IDLE;
            armed         <= 1'b0;
            addr_hit      <= 1'b0;
            addr_ack      <= 1'b0;
            rw_dir        <= 1'b0;
            rw_valid      <= 1'b0;
            need_addr_upd <= 1'b0;
            data_phase    <= 1'b0;
        end else begin
            addr_hit <= 1'b0;
            addr_ack <= 1'b0;
            if (addr_we) begin
                need_addr_upd <= 1'b0;
            end
            if (stop_det) begin
                st       <= ST_IDLE;
                armed    <= 1'b0;
                rw_valid <= 1'b0;
            end else if (start_det) begin
                st       <= ST_ADDR;
                rw_valid <= 1'b0;
            end else begin
                if (nack_det) begin
                    rw_valid <= 1'b0;
                end
                if (byte_vld) begin
                    unique case (st)
                        ST_ADDR: begin
                            if (gc_hit) begin
                                addr_hit   <= 1'b1;
                                addr_ack   <= 1'b1;
                                rw_dir     <= 1'b0;
                                rw_valid   <= 1'b1;
                                data_phase <= 1'b0;
                                st         <= ST_DATA;
                            end else if (!wide_mode && hit7) begin
                                addr_hit   <= 1'b1;
                                addr_ack   <= 1'b1;
                                rw_dir     <= rx_byte[0];
                                rw_valid   <= 1'b1;
                                data_phase <= 1'b0;
                                st         <= ST_DATA;
                            end else if (wide_mode && hi10 && !rx_byte[0]) begin
                                addr_ack      <= 1'b1;
                                need_addr_upd <= 1'b1;
                                armed         <= 1'b0;
                                st            <= ST_LOW;
                            end else if (wide_mode && hi10 && rx_byte[0] && armed) begin
                                addr_hit   <= 1'b1;
                                addr_ack   <= 1'b1;
                                rw_dir     <= 1'b1;
                                rw_valid   <= 1'b1;
                                data_phase <= 1'b0;
                                st         <= ST_DATA;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                        ST_LOW: begin
                            if (lo10) begin
                                addr_hit      <= 1'b1;
                                addr_ack      <= 1'b1;
                                rw_dir        <= 1'b0;
                                rw_valid      <= 1'b1;
                                data_phase    <= 1'b0;
                                need_addr_upd <= 1'b1;
                                armed         <= 1'b1;
                                st            <= ST_DATA;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                        ST_DATA: data_phase <= 1'b1;
                        default: ;
                    endcase
                end
            end
        end
    end

    // R2: a match pulse only ever follows a byte strobe.
    a_r2_hit_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        addr_hit |-> $past(byte_vld));

    // R5: an enabled general call is matched as a write.
    a_r5_gcall_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && !start_det && !stop_det && st == ST_ADDR && gcall_en && rx_byte == '0)
        |=> (addr_hit && addr_ack && !rw_dir));

    // R9: the reload flag only rises in 10-bit mode.
    a_r9_upd_wide_only: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(need_addr_upd) |-> $past(wide_mode));

    // R10: a Stop drops the direction validity.
    a_r10_stop_clears_dir: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !rw_valid);

    // R10: bus events and the byte strobe never share a cycle (input rule).
    a_r10_events_apart: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> !(start_det || stop_det || nack_det));

    // R11: a byte in a selected transfer marks the data phase.
    a_r11_data_marked: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && st == ST_DATA && !start_det && !stop_det) |=> data_phase);

endmodule

// File: rtl/i2c_addr_match.sv
// Top of the I2C slave address matcher.
// Holds the host-written own-address byte and joins the comparator to the
// sequencer. Assumes byte_vld and the bus-event pulses come from a
// bit-level receiver in the same clock domain.
module i2c_addr_match
    import i2c_addr_match_pkg::*;
#(
    parameter int W  = BYTE_W,
    parameter int MW = MASK_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic          nack_det,
    input  logic          byte_vld,
    input  logic [W-1:0]  rx_byte,
    input  logic          addr_we,
    input  logic [W-1:0]  addr_wdata,
    input  logic          wide_mode,
    input  logic          gcall_en,
    input  logic [MW-1:0] mask_sel,
    output logic          addr_hit,
    output logic          addr_ack,
    output logic          rw_dir,
    output logic          rw_valid,
    output logic          need_addr_upd,
    output logic          data_phase
);

    logic [W-1:0] own_addr;
    logic         gc_hit, hit7, hi10, lo10;

    // Own-address byte, written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_addr <= '0;
        end else if (addr_we) begin
            own_addr <= addr_wdata;
        end
    end

    i2c_addr_cmp #(.W(W), .MW(MW)) u_cmp (
        .rx_byte   (rx_byte),
        .own_addr  (own_addr),
        .mask_sel  (mask_sel),
        .wide_mode (wide_mode),
        .gcall_en  (gcall_en),
        .gc_hit    (gc_hit),
        .hit7      (hit7),
        .hi10      (hi10),
        .lo10      (lo10)
    );

    i2c_addr_seq #(.W(W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_det     (start_det),
        .stop_det      (stop_det),
        .nack_det      (nack_det),
        .byte_vld      (byte_vld),
        .rx_byte       (rx_byte),
        .addr_we       (addr_we),
        .wide_mode     (wide_mode),
        .gcall_en      (gcall_en),
        .gc_hit        (gc_hit),
        .hit7          (hit7),
        .hi10          (hi10),
        .lo10          (lo10),
        .addr_hit      (addr_hit),
        .addr_ack      (addr_ack),
        .rw_dir        (rw_dir),
        .rw_valid      (rw_valid),
        .need_addr_upd (need_addr_upd),
        .data_phase    (data_phase)
    );

endmodule

// File: tb/i2c_addr_match_test.sv
`timescale 1ns/1ps
// Self-checking bench: directed corner cases plus seeded random transfers.
module i2c_addr_match_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_det = 1'b0, stop_det = 1'b0, nack_det = 1'b0;
    logic byte_vld = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic addr_we = 1'b0;
    logic [7:0] addr_wdata = 8'h00;
    logic wide_mode = 1'b0, gcall_en = 1'b0;
    logic [4:0] mask_sel = 5'h00;
    logic addr_hit, addr_ack, rw_dir, rw_valid, need_addr_upd, data_phase;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] own_m = 8'h00;
    logic dp_m = 1'b0;

    always #2 clk = ~clk;

    i2c_addr_match uut (
        .clk(clk), .rst_n(rst_n), .start_det(start_det), .stop_det(stop_det),
        .nack_det(nack_det), .byte_vld(byte_vld), .rx_byte(rx_byte),
        .addr_we(addr_we), .addr_wdata(addr_wdata), .wide_mode(wide_mode),
        .gcall_en(gcall_en), .mask_sel(mask_sel), .addr_hit(addr_hit),
        .addr_ack(addr_ack), .rw_dir(rw_dir), .rw_valid(rw_valid),
        .need_addr_upd(need_addr_upd), .data_phase(data_phase)
    );

    // Ignore vector from the requirements (R3, R4).
    function automatic logic [7:0] ign_of(input logic [4:0] m, input logic w);
        return {2'b00, m[4:1], m[0], m[0] & w};
    endfunction

    // Expected 7-bit match (R2, R3, R4, R5).
    function automatic logic exp7(input logic [7:0] b, input logic [7:0] own,
                                  input logic [4:0] m, input logic gc);
        logic [7:0] d;
        d = (b ^ own) & ~ign_of(m, 1'b0);
        if (b == 8'h00) return gc;
        return (b[7:1] != 7'd0) && (d[7:1] == 7'd0);
    endfunction

    // Expected 10-bit low-byte match (R4, R7).
    function automatic logic exp_lo(input logic [7:0] b, input logic [7:0] own,
                                    input logic [4:0] m);
        return ((b ^ own) & ~ign_of(m, 1'b1)) == 8'h00;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk); start_det = 1'b1;
        @(negedge clk); start_det = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); stop_det = 1'b1;
        @(negedge clk); stop_det = 1'b0;
    endtask

    task automatic pulse_nack();
        @(negedge clk); nack_det = 1'b1;
        @(negedge clk); nack_det = 1'b0;
    endtask

    task automatic load_own(input logic [7:0] v);
        @(negedge clk); addr_we = 1'b1; addr_wdata = v;
        @(negedge clk); addr_we = 1'b0;
        own_m = v;
    endtask

    // Drive one byte; on return the registered results are visible.
    task automatic send(input logic [7:0] b);
        @(negedge clk); byte_vld = 1'b1; rx_byte = b;
        @(negedge clk); byte_vld = 1'b0;
    endtask

    // Data bytes after an address phase (R11).
    task automatic data_bytes(input logic sel, input int n);
        for (int i = 0; i < n; i++) begin
            send(8'($urandom));
            if (sel) dp_m = 1'b1;
            chk("R11 data pulse", {addr_hit, addr_ack}, 2'b00);
            chk("R11 data flag", data_phase, dp_m);
        end
    endtask

    initial begin
        #(4ns * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int seed_init;
        logic [7:0] b;
        logic e;
        seed_init = $urandom(32'd20240611);
        repeat (3) idle();
        // R1: reset state
        chk("R1 outputs", {addr_hit, addr_ack, rw_dir, rw_valid, need_addr_upd, data_phase}, 6'd0);
        rst_n = 1'b1;
        idle();

        // R2: exact 7-bit read match
        load_own(8'hA4);
        pulse_start();
        send(8'hA5);
        chk("R2 hit/ack", {addr_hit, addr_ack}, 2'b11);
        chk("R2 dir", {rw_dir, rw_valid}, 2'b11);
        chk("R11 addr flag", data_phase, 1'b0);
        dp_m = 1'b0;
        idle();
        chk("R2 pulse width", {addr_hit, addr_ack}, 2'b00);
        data_bytes(1'b1, 2);
        pulse_nack();
        chk("R10 nack clears", rw_valid, 1'b0);
        pulse_stop();

        // R3: mask on own bit 2
        mask_sel = 5'b00010;
        pulse_start(); send(8'hA0);
        chk("R3 masked hit", {addr_hit, rw_dir}, 2'b10);
        chk("R10 valid", rw_valid, 1'b1);
        dp_m = 1'b0;
        pulse_stop();
        chk("R10 stop clears", rw_valid, 1'b0);
        mask_sel = 5'b00000;
        pulse_start(); send(8'hA0);
        chk("R3 unmasked miss", {addr_hit, addr_ack}, 2'b00);
        data_bytes(1'b0, 1);
        chk("R11 ignored keeps flag", data_phase, dp_m);
        pulse_stop();

        // R4: mask[0] in 7-bit mode ignores bit 1 only
        mask_sel = 5'b00001;
        pulse_start(); send(8'hA6);
        chk("R4 bit1 ignored", {addr_hit, addr_ack}, 2'b11);
        dp_m = 1'b0;
        pulse_stop();
        pulse_start(); send(8'hA2);
        chk("R4 bit2 still compared", addr_hit, 1'b0);
        pulse_stop();

        // R5: general call gating and zero own address
        mask_sel = 5'b00000;
        load_own(8'h00);
        pulse_start(); send(8'h00);
        chk("R5 gc disabled", {addr_hit, addr_ack}, 2'b00);
        pulse_stop();
        gcall_en = 1'b1;
        pulse_start(); send(8'h00);
        chk("R5 gc enabled", {addr_hit, addr_ack, rw_dir}, 3'b110);
        dp_m = 1'b0;
        pulse_stop();
        gcall_en = 1'b0;

        // R6/R7/R8/R9: 10-bit write then read
        wide_mode = 1'b1;
        mask_sel = 5'b00001;
        load_own(8'hF2);
        pulse_start(); send(8'hF2);
        chk("R6 hi ack no hit", {addr_hit, addr_ack}, 2'b01);
        chk("R6 upd set", need_addr_upd, 1'b1);
        load_own(8'h3C);
        chk("R9 upd cleared", need_addr_upd, 1'b0);
        send(8'h3F);
        chk("R4 low bits 1:0 ignored", {addr_hit, addr_ack, rw_dir}, 3'b110);
        chk("R7 upd set again", need_addr_upd, 1'b1);
        dp_m = 1'b0;
        load_own(8'hF2);
        pulse_start(); send(8'hF3);
        chk("R8 read hit", {addr_hit, addr_ack, rw_dir, rw_valid}, 4'b1111);
        dp_m = 1'b0;
        pulse_stop();
        pulse_start(); send(8'hF3);
        chk("R8 no prior match", {addr_hit, addr_ack}, 2'b00);
        pulse_stop();

        // R7: low byte miss
        pulse_start(); send(8'hF2);
        load_own(8'h3C);
        send(8'h34);
        chk("R7 low miss", {addr_hit, addr_ack}, 2'b00);
        pulse_stop();

        // R9: set and write in the same cycle keeps the flag
        load_own(8'hF2);
        pulse_start();
        @(negedge clk); byte_vld = 1'b1; rx_byte = 8'hF2; addr_we = 1'b1; addr_wdata = 8'hF2;
        @(negedge clk); byte_vld = 1'b0; addr_we = 1'b0;
        chk("R9 set wins", need_addr_upd, 1'b1);
        pulse_stop();
        load_own(8'hF2);
        chk("R9 write clears", need_addr_upd, 1'b0);

        // Random 7-bit transfers
        wide_mode = 1'b0;
        for (int t = 0; t < 300; t++) begin
            mask_sel = 5'($urandom);
            gcall_en = 1'($urandom);
            load_own(8'($urandom));
            case ($urandom % 3)
                0: b = own_m ^ (8'($urandom) & ign_of(mask_sel, 1'b0)) ^ 8'($urandom % 2);
                1: b = 8'h00;
                default: b = 8'($urandom);
            endcase
            e = exp7(b, own_m, mask_sel, gcall_en);
            pulse_start(); send(b);
            chk("R2 random hit", {addr_hit, addr_ack}, {e, e});
            if (e) begin
                chk("R2 random dir", rw_dir, (b == 8'h00) ? 1'b0 : b[0]);
                dp_m = 1'b0;
            end
            data_bytes(e, 1 + ($urandom % 2));
            pulse_stop();
        end

        // Random 10-bit write/read transfers
        wide_mode = 1'b1;
        gcall_en = 1'b0;
        for (int t = 0; t < 200; t++) begin
            logic [7:0] hi, lo;
            hi = {5'b11110, 2'($urandom), 1'b0};
            mask_sel = 5'($urandom);
            lo = 8'($urandom);
            load_own(hi);
            pulse_start(); send(hi);
            chk("R6 random hi", {addr_hit, addr_ack, need_addr_upd}, 3'b011);
            load_own(lo);
            b = ($urandom % 2) ? (lo ^ (8'($urandom) & ign_of(mask_sel, 1'b1))) : 8'($urandom);
            e = exp_lo(b, lo, mask_sel);
            send(b);
            chk("R7 random low", {addr_hit, addr_ack}, {e, e});
            chk("R7 random upd", need_addr_upd, e);
            if (e) dp_m = 1'b0;
            data_bytes(e, 1);
            load_own(hi);
            pulse_start(); send(hi | 8'h01);
            chk("R8 random read", {addr_hit, addr_ack}, {e, e});
            if (e) begin
                chk("R8 random dir", rw_dir, 1'b1);
                dp_m = 1'b0;
            end
            pulse_stop();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule